// File: doc/BRIEF.md
# Serial Command Interpreter with Register and Table Load

This block sits behind a byte receiver and turns the received byte stream into configuration writes. Every byte carries its class in bit 7. A byte with bit 7 clear is a command. A byte with bit 7 set is data, and only its low seven bits are payload. A command picks one of several configuration registers, or it switches the block into a table-load mode. The data bytes that follow are packed most significant group first. Once enough of them have arrived, the assembled word goes to the chosen register, or it goes out on a RAM write port at an address that counts up on its own.

A register choice persists. Further groups of data bytes keep writing to the same register until another command arrives. Any command discards a partly assembled word. A command code that names neither a register nor the table load returns the block to idle, and in idle all data is dropped. All logic runs on one clock. The register contents are presented as a flat output vector for the consumer to synchronise.

Top module: `cmd_interp`

## Requirements
- R1: After reset all registers read zero, `ram_we` is low and the block is idle.
- R2: Data bytes (bit 7 = 1) received while idle, including before any command, change no register and cause no RAM write.
- R3: A command with code 0..NUM_REGS-1 in bits 6:0 selects that register. The following three data bytes form the value `{p0,p1,p2}` (7 payload bits each), truncated to its low 16 bits. The register shows the value in the cycle after the third byte, and it does not change after the first or second byte.
- R4: After a register write completes, each further group of three data bytes writes the same register again, until a command arrives.
- R5: Command code 0x7F enters table load with the address counter at zero. Each two data bytes form a 14-bit word `{p0,p1}`. That word is presented on `ram_wdata` with `ram_we` high for one cycle, at the current address, in the cycle after the second byte, and the address then increments.
- R6: A command arriving in the middle of a word discards the partial word. Nothing is written, and assembly for the new target starts from empty.
- R7: A command code from NUM_REGS to 0x7E returns the block to idle without any write, and the data bytes that follow are ignored.
- R8: The table address wraps from 2^LUT_AW-1 to zero.
- R9: A command byte never causes a register or RAM write.
- R10: `ram_we` is high only in the cycle after a table word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte; bit 7 is the class |
| cfg_regs | output | NUM_REGS*REG_W | Register contents, register 0 in the low bits |
| ram_we | output | 1 | Table RAM write strobe |
| ram_addr | output | LUT_AW | Table RAM write address |
| ram_wdata | output | LUT_DW | Table RAM write data |

## Verification
The assertions assume that `rx_valid` is a single-cycle qualifier. A byte is counted once per cycle in which `rx_valid` is high, and `rx_byte` is meaningful only in those cycles. The stimulus drives each byte for exactly one clock, and it changes inputs only on the falling edge, so every byte is seen once. The stimulus also interleaves idle gaps with back-to-back bytes, and it places commands in the middle of words. The properties are therefore exercised both with and without a partial word in flight.

// File: rtl/cmdi_pkg.sv
package cmdi_pkg;
  localparam int PAY_W = 7;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REG = 2'd1, ST_LUT = 2'd2} mode_e;
  typedef enum logic [1:0] {K_DATA = 2'd0, K_REG = 2'd1, K_LUT = 2'd2, K_BAD = 2'd3} kind_e;

  function automatic logic byte_is_cmd(input logic [7:0] b);
    return ~b[7];
  endfunction

  function automatic logic [PAY_W-1:0] byte_payload(input logic [7:0] b);
    return b[PAY_W-1:0];
  endfunction

  function automatic int groups_for(input int width);
    return (width + PAY_W - 1) / PAY_W;
  endfunction
endpackage

// File: rtl/cmdi_decode.sv
module cmdi_decode
  import cmdi_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int LUT_CODE = 127,
  parameter int SEL_W    = 2
) (
  input  logic [7:0]       byte_in,
  output kind_e            kind,
  output logic [SEL_W-1:0] sel
);
  logic [PAY_W-1:0] code;

  always_comb begin
    code = byte_payload(byte_in);
    sel  = '0;
    if (!byte_is_cmd(byte_in)) begin
      kind = K_DATA;
    end else if (int'(code) < NUM_REGS) begin
      kind = K_REG;
      sel  = SEL_W'(code);
    end else if (int'(code) == LUT_CODE) begin
      kind = K_LUT;
    end else begin
      kind = K_BAD;
    end
  end
endmodule

// File: rtl/cmdi_assembler.sv
module cmdi_assembler
  import cmdi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic [PAY_W-1:0]  payload,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int NB    = groups_for(WORD_W);
  localparam int ACC_W = NB * PAY_W;
  localparam int CW    = (NB > 1) ? $clog2(NB + 1) : 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] full;
  logic [CW-1:0]    cnt_q;

  always_comb begin
    full = (acc_q << PAY_W) | ACC_W'(payload);
    word = full[WORD_W-1:0];
    done = shift && (int'(cnt_q) == NB - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear || done) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      acc_q <= full;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmdi_regbank.sv
module cmdi_regbank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int SEL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SEL_W-1:0]          sel,
  input  logic [REG_W-1:0]          wdata,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (we && (int'(sel) == g)) val_q <= wdata;
    end
    assign regs_flat[g*REG_W +: REG_W] = val_q;
  end
endmodule

// File: rtl/cmdi_lut_port.sv
module cmdi_lut_port #(
  parameter int LUT_AW = 8,
  parameter int LUT_DW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [LUT_DW-1:0] wdata,
  output logic              ram_we,
  output logic [LUT_AW-1:0] ram_addr,
  output logic [LUT_DW-1:0] ram_wdata,
  output logic [LUT_AW-1:0] addr_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_cnt  <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= wr;
      if (start) begin
        addr_cnt <= '0;
      end else if (wr) begin
        addr_cnt  <= addr_cnt + 1'b1;
        ram_addr  <= addr_cnt;
        ram_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
  import cmdi_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int LUT_AW   = 8,
  parameter int LUT_DW   = 14,
  parameter int LUT_CODE = 127
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_byte,
  output logic [NUM_REGS*REG_W-1:0] cfg_regs,
  output logic                      ram_we,
  output logic [LUT_AW-1:0]         ram_addr,
  output logic [LUT_DW-1:0]         ram_wdata
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  mode_e            mode_q;
  logic [SEL_W-1:0] sel_q;
  kind_e            kind;
  logic [SEL_W-1:0] dec_sel;
  logic             cmd_evt, data_evt;
  logic             reg_shift, lut_shift;
  logic             reg_wr_evt, lut_wr_evt, lut_enter_evt;
  logic [REG_W-1:0] reg_word;
  logic [LUT_DW-1:0] lut_word;
  logic [LUT_AW-1:0] addr_cnt;
  logic [PAY_W-1:0]  pay;

  cmdi_decode #(.NUM_REGS(NUM_REGS), .LUT_CODE(LUT_CODE), .SEL_W(SEL_W)) i_dec (
    .byte_in(rx_byte), .kind(kind), .sel(dec_sel)
  );

  always_comb begin
    pay           = byte_payload(rx_byte);
    cmd_evt       = rx_valid && (kind != K_DATA);
    data_evt      = rx_valid && (kind == K_DATA);
    reg_shift     = data_evt && (mode_q == ST_REG);
    lut_shift     = data_evt && (mode_q == ST_LUT);
    lut_enter_evt = cmd_evt && (kind == K_LUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ST_IDLE;
      sel_q  <= '0;
    end else if (cmd_evt) begin
      unique case (kind)
        K_REG: begin
          mode_q <= ST_REG;
          sel_q  <= dec_sel;
        end
        K_LUT:   mode_q <= ST_LUT;
        default: mode_q <= ST_IDLE;
      endcase
    end
  end

  cmdi_assembler #(.WORD_W(REG_W)) i_reg_asm (
    .clk(clk), .rst_n(rst_n), .clear(cmd_evt), .shift(reg_shift),
    .payload(pay), .done(reg_wr_evt), .word(reg_word)
  );

  cmdi_assembler #(.WORD_W(LUT_DW)) i_lut_asm (
    .clk(clk), .rst_n(rst_n), .clear(cmd_evt), .shift(lut_shift),
    .payload(pay), .done(lut_wr_evt), .word(lut_word)
  );

  cmdi_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .SEL_W(SEL_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_wr_evt), .sel(sel_q),
    .wdata(reg_word), .regs_flat(cfg_regs)
  );

  cmdi_lut_port #(.LUT_AW(LUT_AW), .LUT_DW(LUT_DW)) i_lut (
    .clk(clk), .rst_n(rst_n), .start(lut_enter_evt), .wr(lut_wr_evt),
    .wdata(lut_word), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .addr_cnt(addr_cnt)
  );
endmodule

// File: rtl/cmdi_checker.sv
module cmdi_checker
  import cmdi_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int LUT_AW   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rx_valid,
  input logic [7:0]                rx_byte,
  input mode_e                     mode_q,
  input logic                      reg_wr_evt,
  input logic                      lut_wr_evt,
  input logic                      lut_enter_evt,
  input logic [LUT_AW-1:0]         addr_cnt,
  input logic [NUM_REGS*REG_W-1:0] cfg_regs,
  input logic                      ram_we,
  input logic [LUT_AW-1:0]         ram_addr
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (mode_q == ST_IDLE) || rst_n); // R1

  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_IDLE && rx_valid && rx_byte[7]) |-> !reg_wr_evt && !lut_wr_evt); // R2

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_evt |=> $stable(cfg_regs)); // R3

  AST_LUT_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lut_enter_evt |=> (addr_cnt == '0)); // R5

  AST_LUT_ADDR_USED: assert property (@(posedge clk) disable iff (!rst_n)
    lut_wr_evt |=> ram_we && (ram_addr == $past(addr_cnt))); // R5

  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_byte[7]) |-> !reg_wr_evt && !lut_wr_evt); // R9

  AST_WE_ONLY_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(lut_wr_evt)); // R10

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_evt, lut_wr_evt})); // R4
endmodule

bind cmd_interp cmdi_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .LUT_AW(LUT_AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .mode_q(mode_q), .reg_wr_evt(reg_wr_evt), .lut_wr_evt(lut_wr_evt),
  .lut_enter_evt(lut_enter_evt), .addr_cnt(addr_cnt), .cfg_regs(cfg_regs),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/test_cmd_interp.sv
`timescale 1ns/1ps
module test_cmd_interp;
  localparam int NR = 4, RW = 16, AW = 8, DW = 14;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [NR*RW-1:0] cfg_regs;
  logic ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmd_interp i_cmd_interp (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cfg_regs(cfg_regs), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  // Behavioural reference: integers and a byte queue per pending word
  int exp_regs [NR];
  int mode = 0, target = 0, ptr = 0;
  int pend[$];
  bit exp_we = 0;
  int exp_addr = 0, exp_wdata = 0;

  function automatic int pack(input int q[$]);
    int v = 0;
    foreach (q[i]) v = v * 128 + q[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (exp_regs[i]) exp_regs[i] = 0;
      mode = 0; ptr = 0; pend.delete(); exp_we = 0;
    end else begin
      exp_we = 0;
      if (rx_valid) begin
        if (rx_byte < 8'h80) begin
          pend.delete();
          if (int'(rx_byte) < NR) begin mode = 1; target = int'(rx_byte); end
          else if (rx_byte == 8'h7F) begin mode = 2; ptr = 0; end
          else mode = 0;
        end else if (mode != 0) begin
          pend.push_back(int'(rx_byte) - 128);
          if (mode == 1 && pend.size() == 3) begin
            exp_regs[target] = pack(pend) % 65536;
            pend.delete();
          end else if (mode == 2 && pend.size() == 2) begin
            exp_we = 1; exp_addr = ptr; exp_wdata = pack(pend) % 16384;
            ptr = (ptr + 1) % 256;
            pend.delete();
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int reg_of(input int i);
    return int'(cfg_regs[i*RW +: RW]);
  endfunction

  // Per-cycle comparison against the model (R3 R4 R5 R10)
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NR; i++)
      check(reg_of(i) == exp_regs[i], "R3/R4 register vs model", reg_of(i), exp_regs[i]);
    check(ram_we == exp_we, "R10 ram_we vs model", int'(ram_we), int'(exp_we));
    if (exp_we) begin
      check(int'(ram_addr) == exp_addr, "R5 ram_addr vs model", int'(ram_addr), exp_addr);
      check(int'(ram_wdata) == exp_wdata, "R5 ram_wdata vs model", int'(ram_wdata), exp_wdata);
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
  endtask

  task automatic gap();
    @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cfg_regs == '0, "R1 regs after reset", int'(cfg_regs[31:0]), 0);
    check(ram_we == 1'b0, "R1 ram_we after reset", int'(ram_we), 0);
    rst_n = 1'b1;
    gap();
    // R2: data before any command
    send(8'h85); send(8'h90); send(8'hFF); gap();
    check(cfg_regs == '0, "R2 data before command", int'(cfg_regs[31:0]), 0);
    // R3: register 1, partial then complete
    send(8'h01); send(8'h83); send(8'hD5); gap();
    check(reg_of(1) == 0, "R3 no update on partial word", reg_of(1), 0);
    send(8'hAA); gap();
    check(reg_of(1) == 16'hEAAA, "R3 register 1 value", reg_of(1), 16'hEAAA);
    // R4: sticky selection, back-to-back bytes
    send(8'h81); send(8'h80); send(8'hFF); gap();
    check(reg_of(1) == 16'h407F, "R4 sticky rewrite", reg_of(1), 16'h407F);
    // R6: abort partial word with new command
    send(8'h02); send(8'h85); send(8'h86);
    send(8'h03); send(8'h80); send(8'h92); send(8'hB4); gap();
    check(reg_of(2) == 0, "R6 partial word discarded", reg_of(2), 0);
    check(reg_of(3) == 16'h0934, "R6 new target fresh", reg_of(3), 16'h0934);
    // R7: unknown command then data
    send(8'h10); send(8'hFF); send(8'hFF); send(8'hFF); gap();
    check(reg_of(1) == 16'h407F && reg_of(0) == 0, "R7 unknown code ignored", reg_of(1), 16'h407F);
    // R5: table load first word
    send(8'h7F); send(8'h95); send(8'hAB); gap();
    check(ram_we && ram_addr == 0 && ram_wdata == 14'h0AAB, "R5 first table word",
          int'(ram_wdata), 14'h0AAB);
    gap();
    check(ram_we == 1'b0, "R10 strobe one cycle", int'(ram_we), 0);
    // R8: fill to wrap
    for (int i = 1; i <= 256; i++) begin
      send(8'h80 | 8'((i >> 7) & 1)); send(8'h80 | 8'(i & 127));
      if (i % 3 == 0) gap();
    end
    gap();
    check(ram_we && ram_addr == 0, "R8 address wraps", int'(ram_addr), 0);
    // R9: command mid-word writes nothing; R5 re-entry resets address
    send(8'h7F); send(8'h8A); send(8'h7F); gap();
    check(ram_we == 1'b0, "R9 command causes no write", int'(ram_we), 0);
    send(8'h81); send(8'h82); gap();
    check(ram_we && ram_addr == 0 && ram_wdata == 14'h0082, "R5 re-entry at zero",
          int'(ram_addr), 0);
    // data after load stays out of registers
    send(8'h20); send(8'h81); send(8'h81); send(8'h81); gap(); gap();
    check(reg_of(3) == 16'h0934, "R7 idle after unknown code", reg_of(3), 16'h0934);
    done = 1'b1;
    summary();
  end
endmodule